// File: doc/BRIEF.md
# Nibble-Serial Register Access Decoder

This block sits on the device side of a byte-wide command link and turns a stream of command bytes into register accesses. Every command byte holds an operation code in its upper four bits and a four-bit payload in its lower four bits. A full 8-bit register address is built from two commands, low nibble first, and so is each 8-bit data byte. Writes land in an internal register file of 256 bytes. Reads place bytes into a small response queue that the host side drains with a valid/ready handshake.

The address register advances by one after every write. It also advances after every read that carries the next-register flag. A host can therefore fill a run of consecutive registers with repeated data pairs, and it can fetch a run of bytes, for example a pair of 24-bit position values, with six flagged reads. Each write is also announced on a one-cycle strobe, with its address and data, for logic elsewhere in the chip.

The command codes are 0x0 for address-low, 0x1 for address-high, 0x2 for data-low, 0x3 for data-high-and-write, and 0x4 for read. For a read, payload bit 0 is the next-register flag. All other codes are ignored.

Top module: `nsr_reg_decoder`

## Requirements
- R1: After reset, rsp_valid and wr_stb are 0, the address is 0x00 and every register reads back as 0x00.
- R2: A command with code 0x0 (byte 0x0N) loads address bits [3:0] with N and leaves bits [7:4] unchanged. Code 0x1 (byte 0x1N) loads address bits [7:4] with N and leaves bits [3:0] unchanged.
- R3: Code 0x2 (byte 0x2N) latches N as the pending low data nibble and writes nothing. Code 0x3 (byte 0x3N) writes {N, latched nibble} to the register at the current address. In the cycle after that command, wr_stb is 1 for exactly one cycle, with wr_addr equal to that address and wr_data equal to the byte written. The address then becomes address+1.
- R4: Repeated 0x2/0x3 pairs fill consecutive registers. The latched low nibble is kept after a write, so a 0x3 command without a new 0x2 reuses it.
- R5: Code 0x4 with payload bit 0 clear (byte 0x40) queues the byte held at the current address and leaves the address unchanged.
- R6: Code 0x4 with payload bit 0 set (byte 0x41) queues the byte at the current address and then advances the address by one. Six such reads return six consecutive registers in address order.
- R7: Codes 0x5 to 0xF, for any payload, and cycles with cmd_valid low write nothing, queue nothing, and leave both the address and the latched low nibble unchanged.
- R8: Queued bytes come out on rsp_byte in command order. Each byte is held stable, with rsp_valid high, until a cycle in which rsp_ready is high. The queue holds 4 bytes.
- R9: A read that arrives while the queue already holds 4 bytes is dropped, but it still advances the address as R6 defines.
- R10: Address increments wrap from 0xFF to 0x00, for writes and for flagged reads alike.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command byte present this cycle |
| cmd_byte | input | 8 | Command: code in [7:4], payload in [3:0] |
| rsp_valid | output | 1 | Response byte available |
| rsp_ready | input | 1 | Host accepts the response byte this cycle |
| rsp_byte | output | 8 | Response byte, oldest first |
| wr_stb | output | 1 | One-cycle pulse announcing a completed register write |
| wr_addr | output | 8 | Address of the announced write |
| wr_data | output | 8 | Data of the announced write |

## Verification
The hardest situation to reach from the ports is a dropped read. Here the response is lost, yet the address must still move, and that movement can only be seen through later traffic. The stimulus holds rsp_ready low and issues five flagged reads, so that the fifth meets a full queue. It then drains the queue and issues an unflagged read, which must return the register one past the dropped one. Wrap-around of the address and the retained low nibble are reached in the same indirect way. A full sweep writes all 256 addresses and reads them back through one unbroken chain of flagged reads. A sweep over every ignored code and payload is followed by a read and by a bare write command.

// File: rtl/nsr_pkg.sv
package nsr_pkg;

  localparam int NIB_W  = 4;
  localparam int BYTE_W = 2 * NIB_W;
  localparam int ADDR_W = BYTE_W;

  typedef enum logic [NIB_W-1:0] {
    OP_ADDR_LO = 4'h0,
    OP_ADDR_HI = 4'h1,
    OP_DATA_LO = 4'h2,
    OP_DATA_WR = 4'h3,
    OP_READ    = 4'h4
  } op_e;

  typedef struct packed {
    logic             ld_alo;
    logic             ld_ahi;
    logic             ld_dlo;
    logic             wr;
    logic             rd;
    logic             rd_next;
    logic [NIB_W-1:0] nib;
  } act_t;

endpackage

// File: rtl/nsr_cmd_decode.sv
module nsr_cmd_decode
  import nsr_pkg::*;
(
  input  logic              cmd_valid,
  input  logic [BYTE_W-1:0] cmd_byte,
  output act_t              act
);

  always_comb begin
    act         = '0;
    act.nib     = cmd_byte[NIB_W-1:0];
    if (cmd_valid) begin
      case (op_e'(cmd_byte[BYTE_W-1:NIB_W]))
        OP_ADDR_LO: act.ld_alo = 1'b1;
        OP_ADDR_HI: act.ld_ahi = 1'b1;
        OP_DATA_LO: act.ld_dlo = 1'b1;
        OP_DATA_WR: act.wr     = 1'b1;
        OP_READ: begin
          act.rd      = 1'b1;
          act.rd_next = cmd_byte[0];
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/nsr_addr_data.sv
module nsr_addr_data
  import nsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  act_t              act,
  output logic [ADDR_W-1:0] addr,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_byte,
  output logic              stb_q,
  output logic [ADDR_W-1:0] stb_addr_q,
  output logic [BYTE_W-1:0] stb_data_q
);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [NIB_W-1:0]  dlo_q, dlo_d;
  logic              addr_adv;
  logic [ADDR_W-1:0] stb_addr_d;
  logic [BYTE_W-1:0] stb_data_d;

  assign addr_adv = act.wr | (act.rd & act.rd_next);
  assign wr_en    = act.wr;
  assign wr_byte  = {act.nib, dlo_q};
  assign addr     = addr_q;

  always_comb begin
    addr_d = addr_q;
    if (act.ld_alo) addr_d[NIB_W-1:0]      = act.nib;
    if (act.ld_ahi) addr_d[ADDR_W-1:NIB_W] = act.nib;
    if (addr_adv)   addr_d                 = addr_q + ADDR_W'(1);
  end

  always_comb begin
    dlo_d = dlo_q;
    if (act.ld_dlo) dlo_d = act.nib;
  end

  always_comb begin
    stb_addr_d = stb_addr_q;
    stb_data_d = stb_data_q;
    if (act.wr) begin
      stb_addr_d = addr_q;
      stb_data_d = wr_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q     <= '0;
      dlo_q      <= '0;
      stb_q      <= 1'b0;
      stb_addr_q <= '0;
      stb_data_q <= '0;
    end else begin
      addr_q     <= addr_d;
      dlo_q      <= dlo_d;
      stb_q      <= act.wr;
      stb_addr_q <= stb_addr_d;
      stb_data_q <= stb_data_d;
    end
  end

  logic idle;
  assign idle = ~(act.ld_alo | act.ld_ahi | act.ld_dlo | act.wr | act.rd);

  // R7: ignored commands leave address and nibble latch untouched
  assert_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> ($stable(addr_q) && $stable(dlo_q) && !stb_q));

  // R3: a write advances the address and raises the strobe
  assert_wr_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    act.wr |=> (stb_q && (addr_q == $past(addr_q) + ADDR_W'(1))
                && (stb_addr_q == $past(addr_q))));

  // R6: flagged read advances the address by one
  assert_rd_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (act.rd && act.rd_next) |=> (addr_q == $past(addr_q) + ADDR_W'(1)));

endmodule

// File: rtl/nsr_regfile.sv
module nsr_regfile
  import nsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [BYTE_W-1:0] rdata
);

  localparam int RF_DEPTH = 2 ** ADDR_W;

  logic [BYTE_W-1:0]   regs_q [RF_DEPTH];
  logic [RF_DEPTH-1:0] row_sel;

  for (genvar g = 0; g < RF_DEPTH; g++) begin : g_row
    assign row_sel[g] = we && (waddr == ADDR_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < RF_DEPTH; i++) regs_q[i] <= '0;
    end else begin
      for (int i = 0; i < RF_DEPTH; i++) begin
        if (row_sel[i]) regs_q[i] <= wdata;
      end
    end
  end

  assign rdata = regs_q[raddr];

endmodule

// File: rtl/nsr_rsp_fifo.sv
module nsr_rsp_fifo
  import nsr_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [BYTE_W-1:0] push_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [BYTE_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              full, do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) ptr_inc = '0;
    else                        ptr_inc = p + PTR_W'(1);
  endfunction

  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign out_valid = (cnt_q != '0);
  assign do_push   = push & ~full;
  assign do_pop    = out_valid & out_ready;
  assign out_data  = mem_q[rd_ptr_q];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (do_push) wr_ptr_d = ptr_inc(wr_ptr_q);
    if (do_pop)  rd_ptr_d = ptr_inc(rd_ptr_q);
    if (do_push && !do_pop)      cnt_d = cnt_q + CNT_W'(1);
    else if (!do_push && do_pop) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_ptr_q] <= push_data;
  end

  // R9: occupancy never exceeds the queue depth
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  // R8: a byte not taken stays in place
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/nsr_reg_decoder.sv
module nsr_reg_decoder
  import nsr_pkg::*;
#(
  parameter int RSP_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [BYTE_W-1:0] cmd_byte,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [BYTE_W-1:0] rsp_byte,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data
);

  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  act_t              act;
  logic [ADDR_W-1:0] cur_addr;
  logic              rf_we;
  logic [BYTE_W-1:0] rf_wdata, rf_rdata;

  nsr_cmd_decode u_dec (
    .cmd_valid (cmd_valid),
    .cmd_byte  (cmd_byte),
    .act       (act)
  );

  nsr_addr_data u_ad (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .act        (act),
    .addr       (cur_addr),
    .wr_en      (rf_we),
    .wr_byte    (rf_wdata),
    .stb_q      (wr_stb),
    .stb_addr_q (wr_addr),
    .stb_data_q (wr_data)
  );

  nsr_regfile u_rf (
    .clk   (clk),
    .rst_n (rst_core_n),
    .we    (rf_we),
    .waddr (cur_addr),
    .wdata (rf_wdata),
    .raddr (cur_addr),
    .rdata (rf_rdata)
  );

  nsr_rsp_fifo #(.DEPTH(RSP_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .push      (act.rd),
    .push_data (rf_rdata),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_data  (rsp_byte)
  );

  // R8: a response leaves the queue only through a handshake
  assert_pop_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    $fell(rsp_valid) |-> $past(rsp_ready));

  // R3: strobe is a single-cycle pulse unless writes arrive back to back
  assert_stb_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (wr_stb && !rf_we) |=> !wr_stb);

endmodule

// File: tb/nsr_reg_decoder_tb.sv
module nsr_reg_decoder_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid;
  logic [7:0] cmd_byte;
  logic       rsp_valid;
  logic       rsp_ready;
  logic [7:0] rsp_byte;
  logic       wr_stb;
  logic [7:0] wr_addr;
  logic [7:0] wr_data;

  always #2 clk = ~clk;

  nsr_reg_decoder u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_byte  (cmd_byte),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_byte  (rsp_byte),
    .wr_stb    (wr_stb),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data)
  );

  int         n_cmp = 0;
  int         n_bad = 0;
  bit         done  = 0;
  logic [7:0] model [256];
  logic       obs_stb;
  logic [7:0] obs_addr, obs_data;
  logic [7:0] cur;

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [3:0] op, input logic [3:0] nib);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_byte  = {op, nib};
    @(negedge clk);
    cmd_valid = 1'b0;
    obs_stb   = wr_stb;
    obs_addr  = wr_addr;
    obs_data  = wr_data;
  endtask

  task automatic set_addr(input logic [7:0] a);
    cmd(4'h0, a[3:0]);
    cmd(4'h1, a[7:4]);
    cur = a;
  endtask

  task automatic write_byte(input logic [7:0] d, input string tag);
    cmd(4'h2, d[3:0]);
    check({tag, " data-low no strobe"}, obs_stb, 0);
    cmd(4'h3, d[7:4]);
    check({tag, " strobe"}, obs_stb, 1);
    check({tag, " wr_addr"}, obs_addr, cur);
    check({tag, " wr_data"}, obs_data, d);
    model[cur] = d;
    cur = cur + 8'd1;
  endtask

  task automatic pop(input logic [7:0] exp, input string tag);
    check({tag, " rsp_valid"}, rsp_valid, 1);
    check({tag, " rsp_byte"}, rsp_byte, exp);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic read_pop(input bit nxt, input string tag);
    cmd(4'h4, {3'b000, nxt});
    pop(model[cur], tag);
    if (nxt) cur = cur + 8'd1;
  endtask

  initial begin
    rst_n     = 1'b0;
    cmd_valid = 1'b0;
    cmd_byte  = 8'h00;
    rsp_ready = 1'b0;
    cur       = 8'h00;
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check("R1 rsp_valid after reset", rsp_valid, 0);
    check("R1 wr_stb after reset", wr_stb, 0);
    read_pop(1'b0, "R1 addr zero read");
    for (int i = 0; i < 256; i++) read_pop(1'b1, "R1 zero sweep");
    check("R10 flagged read wrap", cur, 0);

    // R3: write every address
    for (int a = 0; a < 256; a++) begin
      set_addr(8'(a));
      write_byte(8'((a * 37 + 11) & 8'hff), "R3 sweep");
    end

    // R6 and R10: one chain of flagged reads through all registers
    set_addr(8'h00);
    for (int i = 0; i < 256; i++) read_pop(1'b1, "R6 chain");
    read_pop(1'b0, "R10 chain wrapped to 0x00");

    // R6: six flagged reads return six consecutive registers
    set_addr(8'h37);
    for (int i = 0; i < 6; i++) read_pop(1'b1, "R6 six reads");

    // R2: nibble-wise address loads
    set_addr(8'h5A);
    cmd(4'h0, 4'h3); cur = 8'h53;
    read_pop(1'b0, "R2 low nibble only");
    cmd(4'h1, 4'h7); cur = 8'h73;
    read_pop(1'b0, "R2 high nibble only");

    // R5: unflagged reads do not move the address
    read_pop(1'b0, "R5 repeat read");
    read_pop(1'b0, "R5 repeat read again");

    // R4 and R10: multi-byte write across the wrap
    set_addr(8'hFE);
    write_byte(8'hA1, "R4 multi 0");
    write_byte(8'hB2, "R4 multi 1");
    write_byte(8'hC3, "R10 multi wrap");
    check("R10 write wrap", cur, 8'h01);
    set_addr(8'hFE);
    for (int i = 0; i < 3; i++) read_pop(1'b1, "R4 multi readback");

    // R4: low nibble is reused without a new data-low
    set_addr(8'h20);
    write_byte(8'h15, "R4 latch base");
    cmd(4'h3, 4'h2);
    check("R4 reuse strobe", obs_stb, 1);
    check("R4 reuse wr_addr", obs_addr, 8'h21);
    check("R4 reuse wr_data", obs_data, 8'h25);
    model[8'h21] = 8'h25; cur = 8'h22;
    set_addr(8'h21);
    read_pop(1'b0, "R4 reuse readback");

    // R7: every ignored code with every payload
    set_addr(8'h40);
    cmd(4'h2, 4'h9);
    for (int op = 5; op < 16; op++) begin
      for (int nb = 0; nb < 16; nb++) begin
        cmd(4'(op), 4'(nb));
        check("R7 no strobe", obs_stb, 0);
        check("R7 no response", rsp_valid, 0);
      end
    end
    read_pop(1'b0, "R7 address kept");
    cmd(4'h3, 4'h3);
    check("R7 latch kept strobe", obs_stb, 1);
    check("R7 latch kept wr_addr", obs_addr, 8'h40);
    check("R7 latch kept wr_data", obs_data, 8'h39);
    model[8'h40] = 8'h39; cur = 8'h41;

    // R8 and R9: fill the queue, hold, drop the fifth read
    set_addr(8'h10);
    for (int i = 0; i < 5; i++) cmd(4'h4, 4'h1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R8 held valid", rsp_valid, 1);
      check("R8 held byte", rsp_byte, model[8'h10]);
    end
    for (int i = 0; i < 4; i++) pop(model[8'(8'h10 + i)], "R8 order");
    check("R9 fifth read dropped", rsp_valid, 0);
    cur = 8'h15;
    read_pop(1'b0, "R9 address advanced by dropped read");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule